// File: doc/BRIEF.md
# Packed Element Interleave Unit

This block is a 64-bit permutation stage for packed data. It takes two operands, called first and second. It keeps either the upper or the lower 32-bit half of each one. The two kept halves are then merged into one 64-bit word by alternating their elements. The element width can be 8, 16 or 32 bits.

Inside each pair, the first operand's element takes the less significant position. As a result, the most significant element of the result always comes from the second operand. The least significant element always comes from the first operand. A typical use is to widen narrow packed values. Interleaving data with a zero or sign-copy operand, for example, turns bytes into words.

A build parameter adds an output register. With the register present, a result comes out one cycle after its input is presented with a valid strobe. The output holds its value while no new input arrives. Without the register, the result is combinational. A select code that names no element size raises an illegal flag and forces the result to zero.

Top module: `pack_interleave`

## Requirements
- R1: When `sel_high` is 1, only bits 63:32 of each operand reach the result.
- R2: When `sel_high` is 0, only bits 31:0 of each operand reach the result.
- R3: With `elem_size` = 2'b00 (8-bit elements), result byte 2k holds byte k of the kept first half, and result byte 2k+1 holds byte k of the kept second half, for k = 0..3.
- R4: With `elem_size` = 2'b01 (16-bit elements), result halfword 2k holds halfword k of the kept first half, and result halfword 2k+1 holds halfword k of the kept second half, for k = 0..1.
- R5: With `elem_size` = 2'b10 (32-bit elements), result bits 31:0 hold the kept first half and result bits 63:32 hold the kept second half.
- R6: For every legal size, the top byte of the result equals the top byte of the kept second half, and the bottom byte equals the bottom byte of the kept first half.
- R7: `elem_size` = 2'b11 sets `illegal` to 1 and drives the result to all zeros. Any legal size sets `illegal` to 0.
- R8: With the output register enabled, `out_valid` in a cycle equals `in_valid` in the previous cycle.
- R9: With the output register enabled, `result` and `illegal` keep their values in every cycle that follows a cycle with `in_valid` low.
- R10: While reset is asserted, `out_valid`, `illegal` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Inputs carry a new operation |
| first_op | input | 64 | First operand; supplies the even (lower) element of each pair |
| second_op | input | 64 | Second operand; supplies the odd (upper) element of each pair |
| sel_high | input | 1 | 1 keeps the upper halves, 0 keeps the lower halves |
| elem_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| out_valid | output | 1 | Result is new this cycle |
| result | output | 64 | Interleaved result |
| illegal | output | 1 | Reserved size code was used |

## Verification
The assertions check four things on every cycle:
- the one-cycle valid delay,
- output hold while no input arrives,
- the zero result that goes with the illegal flag,
- the edge-element rule: the top byte comes from the second half and the bottom byte from the first.

Whether each inner element lands in its exact slot can only be shown by the bench's scenarios. These scenarios use the reference operand pair in all six half and size combinations and varied operand patterns. The half selection is also shown only by scenarios in which the two halves of each operand differ.

// File: rtl/pack_interleave_pkg.sv
package pack_interleave_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } elem_size_e;

  localparam int unsigned NUM_SIZES = 3;
endpackage

// File: rtl/pi_half_select.sv
module pi_half_select #(
  parameter int unsigned DATA_W = 64,
  localparam int unsigned HALF_W = DATA_W / 2
) (
  input  logic [DATA_W-1:0] op_in,
  input  logic              sel_high,
  output logic [HALF_W-1:0] half_out
);
  always_comb begin
    if (sel_high) half_out = op_in[DATA_W-1:HALF_W];
    else          half_out = op_in[HALF_W-1:0];
  end
endmodule

// File: rtl/pi_interleave_core.sv
module pi_interleave_core
  import pack_interleave_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  localparam int unsigned HALF_W = DATA_W / 2
) (
  input  logic [HALF_W-1:0] half_a,
  input  logic [HALF_W-1:0] half_b,
  input  elem_size_e        size_sel,
  output logic [DATA_W-1:0] mixed
);
  logic [NUM_SIZES-1:0][DATA_W-1:0] lane;

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    localparam int unsigned EW = 8 << s;
    localparam int unsigned NE = HALF_W / EW;
    for (genvar i = 0; i < NE; i++) begin : g_elem
      assign lane[s][(2*i)*EW +: EW]   = half_a[i*EW +: EW];
      assign lane[s][(2*i+1)*EW +: EW] = half_b[i*EW +: EW];
    end
  end

  always_comb begin
    unique case (size_sel)
      SZ_BYTE: mixed = lane[0];
      SZ_HALF: mixed = lane[1];
      SZ_WORD: mixed = lane[2];
      default: mixed = '0;
    endcase
  end
endmodule

// File: rtl/pi_out_stage.sv
module pi_out_stage #(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld_d,
  input  logic [DATA_W-1:0] res_d,
  input  logic              ill_d,
  output logic              vld_q,
  output logic [DATA_W-1:0] res_q,
  output logic              ill_q
);
  logic [DATA_W-1:0] res_nxt;
  logic              ill_nxt;

  always_comb begin
    res_nxt = res_q;
    ill_nxt = ill_q;
    if (vld_d) begin
      res_nxt = res_d;
      ill_nxt = ill_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
      ill_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      res_q <= res_nxt;
      ill_q <= ill_nxt;
    end
  end
endmodule

// File: rtl/pack_interleave.sv
module pack_interleave
  import pack_interleave_pkg::*;
#(
  parameter int unsigned DATA_W     = 64,
  parameter bit          REGISTERED = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] first_op,
  input  logic [DATA_W-1:0] second_op,
  input  logic              sel_high,
  input  logic [1:0]        elem_size,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              illegal
);
  localparam int unsigned HALF_W = DATA_W / 2;

  logic [HALF_W-1:0] kept_a;
  logic [HALF_W-1:0] kept_b;
  logic [DATA_W-1:0] core_res;
  logic              ill_d;
  elem_size_e        size_e;

  assign size_e = elem_size_e'(elem_size);
  assign ill_d  = (size_e == SZ_RSVD);

  pi_half_select #(.DATA_W(DATA_W)) i_sel_a (
    .op_in(first_op), .sel_high(sel_high), .half_out(kept_a)
  );
  pi_half_select #(.DATA_W(DATA_W)) i_sel_b (
    .op_in(second_op), .sel_high(sel_high), .half_out(kept_b)
  );

  pi_interleave_core #(.DATA_W(DATA_W)) i_core (
    .half_a(kept_a), .half_b(kept_b), .size_sel(size_e), .mixed(core_res)
  );

  if (REGISTERED) begin : g_reg
    pi_out_stage #(.DATA_W(DATA_W)) i_out (
      .clk(clk), .rst_n(rst_n),
      .vld_d(in_valid), .res_d(core_res), .ill_d(ill_d),
      .vld_q(out_valid), .res_q(result), .ill_q(illegal)
    );

    // R8
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
    // R8
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(result) && $stable(illegal)));
  end else begin : g_comb
    assign out_valid = in_valid;
    assign result    = core_res;
    assign illegal   = ill_d;
  end

  // R7
  illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (result == '0));
  // R6
  edge_elem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ill_d |-> (core_res[7:0] == kept_a[7:0] &&
                core_res[DATA_W-1 -: 8] == kept_b[HALF_W-1 -: 8]));
endmodule

// File: tb/test_pack_interleave.sv
module test_pack_interleave;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] first_op, second_op;
  logic        sel_high;
  logic [1:0]  elem_size;
  logic        out_valid;
  logic [63:0] result;
  logic        illegal;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [63:0] exp_res_q[$];
  logic        exp_ill_q[$];
  string       exp_tag_q[$];
  logic [63:0] last_res;
  logic        last_ill;

  always #4 clk = ~clk;

  pack_interleave i_pack_interleave (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .first_op(first_op), .second_op(second_op), .sel_high(sel_high),
    .elem_size(elem_size), .out_valid(out_valid), .result(result),
    .illegal(illegal)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                        input logic hi, input logic [1:0] sz);
    logic [31:0] ka, kb;
    logic [63:0] r;
    int ew, el, w;
    r = '0;
    if (sz == 2'b11) return r;
    ka = hi ? a[63:32] : a[31:0];
    kb = hi ? b[63:32] : b[31:0];
    ew = 8 << sz;
    for (int k = 0; k < 64; k++) begin
      el = k / ew;
      w  = k % ew;
      r[k] = (el % 2 == 0) ? ka[(el/2)*ew + w] : kb[(el/2)*ew + w];
    end
    return r;
  endfunction

  task automatic drive(input logic [63:0] a, input logic [63:0] b, input logic hi,
                       input logic [1:0] sz, input logic [63:0] exp, input string tag);
    @(negedge clk);
    in_valid  = 1'b1;
    first_op  = a;
    second_op = b;
    sel_high  = hi;
    elem_size = sz;
    exp_res_q.push_back(exp);
    exp_ill_q.push_back(sz == 2'b11);
    exp_tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid  = 1'b0;
      first_op  = ~first_op;
      second_op = second_op ^ 64'h5555_AAAA_0F0F_F0F0;
      elem_size = elem_size + 2'd1;
    end
  endtask

  // monitor: samples 2 ns after each rising edge
  initial begin
    last_res = '0;
    last_ill = 1'b0;
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && !done) begin
        check(out_valid == in_valid, "R8 valid delay", {63'd0, out_valid}, {63'd0, in_valid});
        if (out_valid) begin
          if (exp_res_q.size() == 0) begin
            check(1'b0, "R8 unexpected output", result, 64'd0);
          end else begin
            logic [63:0] er;
            logic        ei;
            string       t;
            er = exp_res_q.pop_front();
            ei = exp_ill_q.pop_front();
            t  = exp_tag_q.pop_front();
            check(result == er, t, result, er);
            check(illegal == ei, {t, " illegal flag (R7)"}, {63'd0, illegal}, {63'd0, ei});
          end
          last_res = result;
          last_ill = illegal;
        end else begin
          check(result == last_res && illegal == last_ill, "R9 hold", result, last_res);
        end
      end
    end
  end

  // watchdog
  initial begin
    #(8 * 100000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] a, b;
    rst_n = 1'b0;
    in_valid = 1'b0;
    first_op = '0;
    second_op = '0;
    sel_high = 1'b0;
    elem_size = 2'b00;
    repeat (3) @(posedge clk);
    #2;
    // R10
    check(out_valid == 1'b0 && illegal == 1'b0, "R10 reset flags",
          {62'd0, out_valid, illegal}, 64'd0);
    check(result == 64'd0, "R10 reset result", result, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    a = 64'h7A6A5A4A3A2A1A0A;
    b = 64'h7B6B5B4B3B2B1B0B;
    drive(a, b, 1'b1, 2'b00, 64'h7B7A6B6A5B5A4B4A, "R1 R3 high byte");
    drive(a, b, 1'b1, 2'b01, 64'h7B6B7A6A5B4B5A4A, "R1 R4 high half");
    drive(a, b, 1'b1, 2'b10, 64'h7B6B5B4B7A6A5A4A, "R1 R5 high word");
    drive(a, b, 1'b0, 2'b00, 64'h3B3A2B2A1B1A0B0A, "R2 R3 low byte");
    drive(a, b, 1'b0, 2'b01, 64'h3B2B3A2A1B0B1A0A, "R2 R4 low half");
    drive(a, b, 1'b0, 2'b10, 64'h3B2B1B0B3A2A1A0A, "R2 R5 low word");
    idle(3);
    drive(a, b, 1'b1, 2'b11, 64'd0, "R7 reserved size high");
    idle(2);
    drive(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b0, 2'b00,
          64'h00FF_00FF_00FF_00FF, "R3 R6 zero extend bytes");
    drive(64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 1'b0, 2'b11,
          64'd0, "R7 reserved size low");
    drive(64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 1'b1, 2'b01,
          model(64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 1'b1, 2'b01),
          "R1 R4 R6 mixed pattern");
    for (int i = 0; i < 24; i++) begin
      a = {32'hC0DE_0000 + 32'(i * 977), 32'h1234_5678 ^ 32'(i * 40503)};
      b = {32'h8000_0001 * 32'(i + 3), 32'hA5A5_0000 + 32'(i * 6007)};
      drive(a, b, i[0], 2'(i % 4), model(a, b, i[0], 2'(i % 4)),
            "R3 R4 R5 R7 sweep");
      if (i % 5 == 0) idle(1);
    end
    idle(4);
    check(exp_res_q.size() == 0, "R8 all results delivered",
          64'(exp_res_q.size()), 64'd0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule